// File: doc/BRIEF.md
# JK Excitation-Table State Sequencer

This block is a three-state synchronous sequencer. Its state lives in two JK flip-flops. On each enabled clock a 2-bit symbol code picks one of four input symbols. A fixed excitation decoder turns the current state and that symbol into the J and K inputs of both flip-flops, and each flip-flop then holds, clears, sets or toggles according to its pair. The next state is therefore never coded directly. It comes from the excitation pairs together with the JK rule, and two of the twelve transitions use the toggle mode.

The two state bits and the four excitation signals are all visible at the ports. A user can check the excitation pattern in the cycle the symbol is applied, and check the resulting state one clock later. A sample-enable input freezes the state when it is low. The unused state code returns the sequencer to its idle state on the next enabled clock.

Top module: `jkseq_top`

## Requirements
- R1: While the active-low reset `rstN` is low, `stateQ` is 2'b00 (idle state A).
- R2: Each flip-flop follows the JK rule on an enabled rising clock edge: J=0/K=0 keeps the bit, J=0/K=1 makes it 0, J=1/K=0 makes it 1, and J=1/K=1 inverts it.
- R3: In state A (`stateQ`=00), the symbol codes 00, 01, 10 and 11 give `excite` = 0110, 0001, 1001 and 0101. Symbol 00 therefore moves to state B (01), symbol 10 moves to state C (10), and symbols 01 and 11 stay in A.
- R4: In state B (`stateQ`=01), the symbol codes 00, 01, 10 and 11 give `excite` = 0110, 0001, 0100 and 0011. Symbols 00 and 10 stay in B, and symbols 01 and 11 return to A; symbol 11 does so by toggling `stateQ[0]`.
- R5: In state C (`stateQ`=10), the symbol codes 00, 01, 10 and 11 give `excite` = 1000, 1100, 1001 and 0101. Symbols 00 and 10 stay in C, and symbols 01 and 11 return to A; symbol 01 does so by toggling `stateQ[1]`.
- R6: With the unused code `stateQ`=11, `excite` is 0101 for every symbol, and the next enabled clock edge gives `stateQ`=00.
- R7: While `sampleEn` is low, `stateQ` does not change on a clock edge. `excite` still shows the table entry.
- R8: `excite` is combinational. It reflects the present `stateQ` and `symbol` in the same cycle, and `stateQ` reflects a step one rising edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | When high, the flip-flops update on this edge |
| symbol | input | 2 | Input symbol code, 00 to 11 |
| stateQ | output | 2 | State bits: [1] is flip-flop 1, [0] is flip-flop 2 |
| excite | output | 4 | Excitation {J1,K1,J2,K2}: J1 on bit 3, K2 on bit 0 |

## Verification
The excitation pattern is due in the same cycle the symbol and enable are driven, because it passes through no register. The bench drives at the falling edge and reads `excite` two time units later. The state change passes through a single register, so the bench reads `stateQ` just after the following rising edge. A scoreboard entry carries both the expected pattern and the expected next state, so each entry covers that one-cycle offset. The unused code cannot be reached through the table, so the bench places it in the flip-flops while reset is being released. It then checks the held value with the enable low, and checks the return to state A on the first enabled edge.

// File: rtl/jkseq_pkg.sv
package jkseq_pkg;
  parameter int STATE_W = 2;
  parameter int SYM_W   = 2;
  localparam int EXC_W  = 2 * STATE_W;

  // Strobes from the decoder into the flip-flop datapath.
  typedef struct packed {
    logic j1;
    logic k1;
    logic j2;
    logic k2;
  } exciteT;

  typedef enum logic [STATE_W-1:0] {
    ST_A      = 2'b00,
    ST_B      = 2'b01,
    ST_C      = 2'b10,
    ST_UNUSED = 2'b11
  } stateT;
endpackage

// File: rtl/jk_cell.sv
module jk_cell (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic j,
  input  logic k,
  output logic q
);
  logic qReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        qReg <= 1'b0;
    else if (en) begin
      case ({j, k})
        2'b01:   qReg <= 1'b0;
        2'b10:   qReg <= 1'b1;
        2'b11:   qReg <= ~qReg;
        default: qReg <= qReg;
      endcase
    end
  end

  assign q = qReg;

  assert_jk_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (en && j && !k) |=> q);
  assert_jk_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (en && !j && k) |=> !q);
  assert_jk_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (en && j && k) |=> (q != $past(q)));
  assert_jk_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!en || (!j && !k)) |=> $stable(q));
endmodule

// File: rtl/jkseq_ctrl.sv
module jkseq_ctrl
  import jkseq_pkg::*;
(
  input  logic [STATE_W-1:0] curState,
  input  logic [SYM_W-1:0]   symbol,
  output exciteT             strobes
);
  logic [EXC_W-1:0] pattern;

  always_comb begin
    case ({curState, symbol})
      4'b00_00: pattern = 4'b0110;
      4'b00_01: pattern = 4'b0001;
      4'b00_10: pattern = 4'b1001;
      4'b00_11: pattern = 4'b0101;
      4'b01_00: pattern = 4'b0110;
      4'b01_01: pattern = 4'b0001;
      4'b01_10: pattern = 4'b0100;
      4'b01_11: pattern = 4'b0011;
      4'b10_00: pattern = 4'b1000;
      4'b10_01: pattern = 4'b1100;
      4'b10_10: pattern = 4'b1001;
      4'b10_11: pattern = 4'b0101;
      default:  pattern = 4'b0101; // unused code: clear both bits
    endcase
  end

  assign strobes = exciteT'(pattern);

  // R6: the unused code always clears both flip-flops (no set and no toggle).
  always_comb begin
    if (curState == ST_UNUSED)
      assert_unused_clears_R6: assert (!strobes.j1 && !strobes.j2 && strobes.k1 && strobes.k2);
  end
endmodule

// File: rtl/jkseq_datapath.sv
module jkseq_datapath
  import jkseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  exciteT             strobes,
  output logic [STATE_W-1:0] stateQ
);
  logic [STATE_W-1:0] jVec;
  logic [STATE_W-1:0] kVec;

  assign jVec = {strobes.j1, strobes.j2};
  assign kVec = {strobes.k1, strobes.k2};

  for (genvar g = 0; g < STATE_W; g++) begin : g_cell
    jk_cell u_cell (
      .clk  (clk),
      .rstN (rstN),
      .en   (sampleEn),
      .j    (jVec[g]),
      .k    (kVec[g]),
      .q    (stateQ[g])
    );
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> (stateQ == '0));
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> $stable(stateQ));
endmodule

// File: rtl/jkseq_top.sv
module jkseq_top
  import jkseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleEn,
  input  logic [SYM_W-1:0]   symbol,
  output logic [STATE_W-1:0] stateQ,
  output logic [EXC_W-1:0]   excite
);
  exciteT strobes;

  jkseq_ctrl u_ctrl (
    .curState (stateQ),
    .symbol   (symbol),
    .strobes  (strobes)
  );

  jkseq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .strobes  (strobes),
    .stateQ   (stateQ)
  );

  assign excite = strobes;

  assert_a_to_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && stateQ == ST_A && symbol == 2'b00) |=> (stateQ == ST_B));
  assert_a_to_c_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && stateQ == ST_A && symbol == 2'b10) |=> (stateQ == ST_C));
  assert_b_return_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && stateQ == ST_B && symbol[0]) |=> (stateQ == ST_A));
  assert_c_return_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && stateQ == ST_C && symbol[0]) |=> (stateQ == ST_A));
  assert_unused_recovers_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && stateQ == ST_UNUSED) |=> (stateQ == ST_A));
endmodule

// File: tb/jkseq_top_tb.sv
module jkseq_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b0;
  logic [1:0] symbol = 2'b00;
  logic [1:0] stateQ;
  logic [3:0] excite;

  int total = 0;
  int bad = 0;
  logic [1:0] modelState = 2'b00;

  typedef struct {
    logic [3:0] expExcite;
    logic [1:0] expState;
    string      tag;
  } itemT;
  itemT sbQ[$];

  always #5 clk = ~clk;

  jkseq_top u_dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn),
    .symbol(symbol), .stateQ(stateQ), .excite(excite)
  );

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Specification tables: R3 (state A), R4 (state B), R5 (state C), R6 (unused).
  function automatic logic [3:0] refExcite(input logic [1:0] st, input logic [1:0] sy);
    logic [3:0] a [4] = '{4'b0110, 4'b0001, 4'b1001, 4'b0101};
    logic [3:0] b [4] = '{4'b0110, 4'b0001, 4'b0100, 4'b0011};
    logic [3:0] c [4] = '{4'b1000, 4'b1100, 4'b1001, 4'b0101};
    case (st)
      2'b00:   return a[sy];
      2'b01:   return b[sy];
      2'b10:   return c[sy];
      default: return 4'b0101;
    endcase
  endfunction

  // R2: JK rule for one bit.
  function automatic logic jkRule(input logic q, input logic j, input logic k);
    return (j & k) ? ~q : (j ? 1'b1 : (k ? 1'b0 : q));
  endfunction

  function automatic string stateTag(input logic [1:0] st);
    return (st == 2'b00) ? "R3" : (st == 2'b01) ? "R4" : (st == 2'b10) ? "R5" : "R6";
  endfunction

  // Driver: applies one step and pushes what the design owes for it.
  task automatic drive(input logic [1:0] sy, input bit en);
    itemT it;
    logic [3:0] e;
    @(negedge clk);
    symbol = sy;
    sampleEn = en;
    e = refExcite(modelState, sy);
    it.expExcite = e;
    it.expState = en ? {jkRule(modelState[1], e[3], e[2]), jkRule(modelState[0], e[1], e[0])}
                     : modelState;
    it.tag = en ? stateTag(modelState) : "R7";
    modelState = it.expState;
    sbQ.push_back(it);
  endtask

  // Monitor: pattern due in the same cycle (R8), state due after the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbQ.size() > 0) begin
        itemT it;
        it = sbQ.pop_front();
        check(excite == it.expExcite, {it.tag, " R8 excite"}, excite, it.expExcite);
        @(posedge clk);
        #2;
        check(stateQ == it.expState, {it.tag, " R2 next state"}, {2'b00, stateQ}, {2'b00, it.expState});
      end
    end
  end

  task automatic finishRun;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  task automatic goTo(input logic [1:0] st);
    drive(2'b01, 1'b1);                 // returns to A from any valid state
    if (st == 2'b01) drive(2'b00, 1'b1);
    if (st == 2'b10) drive(2'b10, 1'b1);
  endtask

  task automatic drain;
    @(negedge clk);
    sampleEn = 1'b0;
    while (sbQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(stateQ == 2'b00, "R1 reset state", {2'b00, stateQ}, 4'b0000);
    @(negedge clk);
    rstN = 1'b1;

    // All twelve state/symbol pairs (R3, R4, R5, with toggles for R2).
    for (int st = 0; st < 3; st++) begin
      for (int sy = 0; sy < 4; sy++) begin
        goTo(2'(st));
        drive(2'(sy), 1'b1);
      end
    end

    // Enable low: state frozen, pattern still shown (R7).
    goTo(2'b10);
    drive(2'b01, 1'b0);
    drive(2'b11, 1'b0);
    drive(2'b01, 1'b1);
    goTo(2'b01);
    drive(2'b11, 1'b0);
    drive(2'b11, 1'b1);
    drain();

    // Unused code 11 placed while reset is released (R6).
    @(negedge clk);
    rstN = 1'b0;
    symbol = 2'b10;
    @(negedge clk);
    force u_dut.u_dp.g_cell[0].u_cell.qReg = 1'b1;
    force u_dut.u_dp.g_cell[1].u_cell.qReg = 1'b1;
    rstN = 1'b1;
    #1;
    release u_dut.u_dp.g_cell[0].u_cell.qReg;
    release u_dut.u_dp.g_cell[1].u_cell.qReg;
    #1;
    check(stateQ == 2'b11, "R6 unused code present", {2'b00, stateQ}, 4'b0011);
    check(excite == 4'b0101, "R6 unused excite", excite, 4'b0101);
    @(posedge clk);
    #2;
    check(stateQ == 2'b11, "R7 unused held while disabled", {2'b00, stateQ}, 4'b0011);
    @(negedge clk);
    sampleEn = 1'b1;
    symbol = 2'b00;
    #2;
    check(excite == 4'b0101, "R6 unused excite other symbol", excite, 4'b0101);
    @(posedge clk);
    #2;
    check(stateQ == 2'b00, "R6 recovery to A", {2'b00, stateQ}, 4'b0000);
    @(negedge clk);
    sampleEn = 1'b0;
    modelState = 2'b00;

    // Back in normal operation after recovery (R3).
    drive(2'b10, 1'b1);
    drive(2'b11, 1'b1);
    drain();
    finishRun();
  end
endmodule